// File: doc/BRIEF.md
# Out-of-Order Issue Window for a Floating-Point Pipeline

This block sits between decode and the floating-point execution units of a pipelined core. Decoded three-register operations arrive one per cycle, in program order, and are held in a small window. Every cycle the window looks at all waiting operations. Any operation whose unit is free and whose registers are clear of hazards may start, even when older operations are still stalled. Operand data does not pass through the block. It tracks only scheduling state: which registers have a write in flight, which unit is busy, and the relative age of each operation.

Two units are modelled. The add/subtract unit is pipelined, has a latency of 4 and accepts one new operation per cycle. The divider has a latency of 7, is not pipelined and stays busy until its result has been written back. The two units share a single writeback port. When both finish in the same cycle, the older operation goes first and the other is held for one cycle. Because no register renaming is done, a write-after-write or write-after-read conflict holds the younger operation back, just as a read-after-write dependence does.

Top module: `ooo_issue_window`

## Requirements
- R1: While fewer than 4 operations are held, `in_ready` is high. With 4 held, it is low and `in_valid` is not taken. An operation is accepted on a clock edge where both are high. In the cycle after an operation leaves a full window, `in_ready` is high again.
- R2: Consider an operation accepted on edge E that meets no hazard and finds its unit free. For an add/subtract (`in_is_div`=0), `wb_valid` is high for one cycle, starting at edge E+4. For a divide (`in_is_div`=1), it starts at edge E+7. `wb_tag` and `wb_dst` carry the operation's tag and destination.
- R3: A younger operation that is free of hazards starts execution while an older, blocked operation is still waiting.
- R4: An operation that reads a register written by an older operation stays waiting. This holds while that older operation is still in the window, or until it has written back. It starts at the earliest in the cycle after that writeback.
- R5: An operation whose destination matches the destination of an older operation waits under the same rule as R4.
- R6: An operation whose destination matches a source of an older operation still in the window waits until that older operation has left the window.
- R7: The add/subtract unit accepts a new operation every cycle. A divide starts only when no other divide is in the unit; the earliest is the cycle after the previous divide's writeback.
- R8: When several waiting operations for the same unit are eligible, the oldest starts first.
- R9: There is one writeback per cycle. When both units finish together, the older operation writes back first and the other writes back in the next cycle. While the add/subtract unit is held, its pipeline is frozen.
- R10: During and just after reset, `in_ready` is high and `wb_valid` is low.
- R11: Operations may write back in an order different from program order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A decoded operation is offered |
| in_ready | output | 1 | The window can take an operation this cycle |
| in_is_div | input | 1 | 1 = divide, 0 = add/subtract |
| in_dst | input | 5 | Destination register index |
| in_src_a | input | 5 | First source register index |
| in_src_b | input | 5 | Second source register index |
| in_tag | input | 6 | Identifier returned at writeback |
| wb_valid | output | 1 | An operation writes back this cycle |
| wb_tag | output | 6 | Identifier of the operation writing back |
| wb_dst | output | 5 | Destination register being written |

## Verification
A corrupted pending-write bit or age tag does not show up as a bad value. It shows up as a writeback in the wrong cycle or in the wrong order. A missed hazard makes an operation write back 4 or 7 cycles after issue, when it should have waited for its producer. A lost pending clear or a stuck busy divider delays every later dependent writeback indefinitely. The bench therefore fixes the exact writeback cycle, tag and destination of every operation across dependence chains, unit collisions and a full window. Any error in hazard, age or busy state appears at the first writeback it affects, at most 7 cycles after the wrong dispatch.

// File: rtl/iw_pkg.sv
// Package iw_pkg: shared unit encoding and the wrap-safe age comparison
// used by every part of the issue window.
// Assumes: sequence tags are at most 16 bits wide.
package iw_pkg;

    typedef enum logic {
        UNIT_ADDSUB = 1'b0,
        UNIT_DIV    = 1'b1
    } unit_e;

    // True when tag a was issued before tag b (modulo 2**w arithmetic).
    function automatic logic seq_older(input logic [15:0] a,
                                       input logic [15:0] b,
                                       input int unsigned w);
        logic [15:0] diff;
        diff = a - b;
        return diff[w-1];
    endfunction

endpackage

// File: rtl/iw_window.sv
// Module iw_window: holds up to DEPTH waiting operations with age tags,
// checks each against the pending-write bits and all older residents for
// RAW, WAW and WAR conflicts, and picks the oldest eligible per unit.
// Assumes: pend reflects dispatched-but-not-written-back destinations.
module iw_window
    import iw_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int NREG  = 32,
    parameter int REG_W = 5,
    parameter int TAG_W = 6,
    parameter int SEQ_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_is_div,
    input  logic [REG_W-1:0] in_dst,
    input  logic [REG_W-1:0] in_src_a,
    input  logic [REG_W-1:0] in_src_b,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [NREG-1:0]  pend,
    input  logic             add_free,
    input  logic             div_free,
    output logic             add_go,
    output logic [TAG_W-1:0] add_tag,
    output logic [REG_W-1:0] add_dst,
    output logic [SEQ_W-1:0] add_seq,
    output logic             div_go,
    output logic [TAG_W-1:0] div_tag,
    output logic [REG_W-1:0] div_dst,
    output logic [SEQ_W-1:0] div_seq
);
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] e_vld;
    logic [DEPTH-1:0] e_div;
    logic [REG_W-1:0] e_dst [DEPTH];
    logic [REG_W-1:0] e_sa  [DEPTH];
    logic [REG_W-1:0] e_sb  [DEPTH];
    logic [TAG_W-1:0] e_tag [DEPTH];
    logic [SEQ_W-1:0] e_seq [DEPTH];
    logic [SEQ_W-1:0] seq_ctr;

    logic [DEPTH-1:0] blk, rdy_add, rdy_div, pick_add, pick_div, take;
    logic [SLOT_W-1:0] slot;
    logic             alloc;

    assign in_ready = ~(&e_vld);
    assign alloc    = in_valid && in_ready;

    // Hazard detection for each resident against scoreboard and older residents.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            blk[i] = pend[e_sa[i]] | pend[e_sb[i]] | pend[e_dst[i]];
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && e_vld[j] &&
                    seq_older(16'(e_seq[j]), 16'(e_seq[i]), SEQ_W)) begin
                    if (e_dst[j] == e_sa[i] || e_dst[j] == e_sb[i] ||
                        e_dst[j] == e_dst[i] ||
                        e_sa[j] == e_dst[i] || e_sb[j] == e_dst[i])
                        blk[i] = 1'b1;
                end
            end
            rdy_add[i] = e_vld[i] && !e_div[i] && !blk[i];
            rdy_div[i] = e_vld[i] &&  e_div[i] && !blk[i];
        end
    end

    // Oldest-first choice among eligible residents, separately per unit.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            pick_add[i] = rdy_add[i];
            pick_div[i] = rdy_div[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && seq_older(16'(e_seq[j]), 16'(e_seq[i]), SEQ_W)) begin
                    if (rdy_add[j]) pick_add[i] = 1'b0;
                    if (rdy_div[j]) pick_div[i] = 1'b0;
                end
            end
        end
    end

    // Dispatch outputs muxed from the chosen residents.
    always_comb begin
        add_go  = (|pick_add) && add_free;
        div_go  = (|pick_div) && div_free;
        add_tag = '0; add_dst = '0; add_seq = '0;
        div_tag = '0; div_dst = '0; div_seq = '0;
        for (int i = 0; i < DEPTH; i++) begin
            take[i] = (pick_add[i] && add_free) || (pick_div[i] && div_free);
            if (pick_add[i]) begin
                add_tag = e_tag[i]; add_dst = e_dst[i]; add_seq = e_seq[i];
            end
            if (pick_div[i]) begin
                div_tag = e_tag[i]; div_dst = e_dst[i]; div_seq = e_seq[i];
            end
        end
    end

    // Lowest free slot receives the next arrival.
    always_comb begin
        slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!e_vld[i]) slot = SLOT_W'(i);
    end

    // Resident storage: release dispatched entries, write the new arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_vld   <= '0;
            seq_ctr <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (take[i]) e_vld[i] <= 1'b0;
                if (alloc && slot == SLOT_W'(i)) begin
                    e_vld[i] <= 1'b1;
                    e_div[i] <= in_is_div;
                    e_dst[i] <= in_dst;
                    e_sa[i]  <= in_src_a;
                    e_sb[i]  <= in_src_b;
                    e_tag[i] <= in_tag;
                    e_seq[i] <= seq_ctr;
                end
            end
            if (alloc) seq_ctr <= seq_ctr + 1'b1;
        end
    end

    // A dispatch out of a full window frees room by the next cycle.
    p_room_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && (|take)) |=> in_ready);

endmodule

// File: rtl/iw_add_pipe.sv
// Module iw_add_pipe: LAT-stage pipelined add/subtract timing model.
// Accepts one operation per cycle; the whole pipe freezes on stall.
// Assumes: go is never asserted while stall is high.
module iw_add_pipe #(
    parameter int LAT   = 4,
    parameter int REG_W = 5,
    parameter int TAG_W = 6,
    parameter int SEQ_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [TAG_W-1:0] go_tag,
    input  logic [REG_W-1:0] go_dst,
    input  logic [SEQ_W-1:0] go_seq,
    input  logic             stall,
    output logic             out_vld,
    output logic [TAG_W-1:0] out_tag,
    output logic [REG_W-1:0] out_dst,
    output logic [SEQ_W-1:0] out_seq
);
    logic [LAT-1:0]   st_v;
    logic [TAG_W-1:0] st_tag [LAT];
    logic [REG_W-1:0] st_dst [LAT];
    logic [SEQ_W-1:0] st_seq [LAT];

    // Advance every stage unless the result at the tail is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_v <= '0;
        end else if (!stall) begin
            st_v[0]   <= go;
            st_tag[0] <= go_tag;
            st_dst[0] <= go_dst;
            st_seq[0] <= go_seq;
            for (int k = 1; k < LAT; k++) begin
                st_v[k]   <= st_v[k-1];
                st_tag[k] <= st_tag[k-1];
                st_dst[k] <= st_dst[k-1];
                st_seq[k] <= st_seq[k-1];
            end
        end
    end

    assign out_vld = st_v[LAT-1];
    assign out_tag = st_tag[LAT-1];
    assign out_dst = st_dst[LAT-1];
    assign out_seq = st_seq[LAT-1];

    // A result losing writeback stays presented unchanged.
    p_add_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (out_vld && $stable(out_tag)));

endmodule

// File: rtl/iw_div_unit.sv
// Module iw_div_unit: unpipelined divider timing model. Busy from dispatch
// until its result is taken by the writeback port.
// Assumes: go is asserted only while busy is low.
module iw_div_unit #(
    parameter int LAT   = 7,
    parameter int REG_W = 5,
    parameter int TAG_W = 6,
    parameter int SEQ_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [TAG_W-1:0] go_tag,
    input  logic [REG_W-1:0] go_dst,
    input  logic [SEQ_W-1:0] go_seq,
    input  logic             take,
    output logic             busy,
    output logic             done,
    output logic [TAG_W-1:0] out_tag,
    output logic [REG_W-1:0] out_dst,
    output logic [SEQ_W-1:0] out_seq
);
    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

    logic [CNT_W-1:0] cnt;

    assign done = busy && (cnt == '0);

    // Count down the latency, then hold until the result is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (go) begin
            busy    <= 1'b1;
            cnt     <= CNT_W'(LAT - 1);
            out_tag <= go_tag;
            out_dst <= go_dst;
            out_seq <= go_seq;
        end else if (busy) begin
            if (cnt != '0)
                cnt <= cnt - 1'b1;
            else if (take)
                busy <= 1'b0;
        end
    end

    // Only one divide in the unit at a time.
    p_div_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);

    // An unaccepted result waits with the same identity.
    p_div_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !take) |=> (done && $stable(out_tag)));

endmodule

// File: rtl/iw_wb_arb.sv
// Module iw_wb_arb: grants the single writeback port to the older of the
// two finishing units.
// Assumes: sequence tags of in-flight operations are within half the tag range.
module iw_wb_arb
    import iw_pkg::*;
#(
    parameter int SEQ_W = 6
) (
    input  logic             add_v,
    input  logic [SEQ_W-1:0] add_seq,
    input  logic             div_v,
    input  logic [SEQ_W-1:0] div_seq,
    output logic             grant_add,
    output logic             grant_div
);
    // Age-ordered grant between the two candidates.
    always_comb begin
        grant_div = div_v && (!add_v ||
                    seq_older(16'(div_seq), 16'(add_seq), SEQ_W));
        grant_add = add_v && !grant_div;
    end
endmodule

// File: rtl/ooo_issue_window.sv
// Module ooo_issue_window: top of the issue window. Ties the window, the two
// unit models, the writeback arbiter and the per-register pending-write
// scoreboard together.
// Assumes: a single in-flight writer per register (guaranteed by WAW blocking).
module ooo_issue_window #(
    parameter int DEPTH   = 4,
    parameter int NREG    = 32,
    parameter int TAG_W   = 6,
    parameter int ADD_LAT = 4,
    parameter int DIV_LAT = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_is_div,
    input  logic [$clog2(NREG)-1:0] in_dst,
    input  logic [$clog2(NREG)-1:0] in_src_a,
    input  logic [$clog2(NREG)-1:0] in_src_b,
    input  logic [TAG_W-1:0]        in_tag,
    output logic                    wb_valid,
    output logic [TAG_W-1:0]        wb_tag,
    output logic [$clog2(NREG)-1:0] wb_dst
);
    localparam int REG_W = $clog2(NREG);
    localparam int SEQ_W = $clog2(2 * (DEPTH + ADD_LAT + 1)) + 1;

    logic [NREG-1:0]  pend, pend_nxt;
    logic             add_go, div_go, add_free, div_free;
    logic [TAG_W-1:0] add_tag, div_tag, ao_tag, do_tag;
    logic [REG_W-1:0] add_dst, div_dst, ao_dst, do_dst;
    logic [SEQ_W-1:0] add_seq, div_seq, ao_seq, do_seq;
    logic             ao_vld, do_done, div_busy, g_add, g_div;

    assign add_free = !(ao_vld && !g_add);
    assign div_free = !div_busy;

    iw_window #(.DEPTH(DEPTH), .NREG(NREG), .REG_W(REG_W),
                .TAG_W(TAG_W), .SEQ_W(SEQ_W)) u_window (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_is_div(in_is_div),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_tag(in_tag), .pend(pend),
        .add_free(add_free), .div_free(div_free),
        .add_go(add_go), .add_tag(add_tag), .add_dst(add_dst), .add_seq(add_seq),
        .div_go(div_go), .div_tag(div_tag), .div_dst(div_dst), .div_seq(div_seq)
    );

    iw_add_pipe #(.LAT(ADD_LAT), .REG_W(REG_W), .TAG_W(TAG_W),
                  .SEQ_W(SEQ_W)) u_add (
        .clk(clk), .rst_n(rst_n),
        .go(add_go), .go_tag(add_tag), .go_dst(add_dst), .go_seq(add_seq),
        .stall(!add_free),
        .out_vld(ao_vld), .out_tag(ao_tag), .out_dst(ao_dst), .out_seq(ao_seq)
    );

    iw_div_unit #(.LAT(DIV_LAT), .REG_W(REG_W), .TAG_W(TAG_W),
                  .SEQ_W(SEQ_W)) u_div (
        .clk(clk), .rst_n(rst_n),
        .go(div_go), .go_tag(div_tag), .go_dst(div_dst), .go_seq(div_seq),
        .take(g_div), .busy(div_busy), .done(do_done),
        .out_tag(do_tag), .out_dst(do_dst), .out_seq(do_seq)
    );

    iw_wb_arb #(.SEQ_W(SEQ_W)) u_arb (
        .add_v(ao_vld), .add_seq(ao_seq),
        .div_v(do_done), .div_seq(do_seq),
        .grant_add(g_add), .grant_div(g_div)
    );

    assign wb_valid = g_add || g_div;
    assign wb_tag   = g_div ? do_tag : ao_tag;
    assign wb_dst   = g_div ? do_dst : ao_dst;

    // Scoreboard next state: clear on writeback, set on dispatch.
    always_comb begin
        pend_nxt = pend;
        if (wb_valid) pend_nxt[wb_dst]  = 1'b0;
        if (add_go)   pend_nxt[add_dst] = 1'b1;
        if (div_go)   pend_nxt[div_dst] = 1'b1;
    end

    // Scoreboard register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nxt;
    end

    // Every writeback retires a register that was marked in flight.
    p_wb_was_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> pend[wb_dst]);

    // No dispatch onto a register that already has a write in flight.
    p_add_no_waw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        add_go |-> !pend[add_dst]);

    p_div_no_waw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |-> !pend[div_dst]);

endmodule

// File: tb/ooo_issue_window_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected writebacks (tag, destination, cycle) in
// completion order; a monitor pops and compares on every writeback.
module ooo_issue_window_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_is_div = 1'b0;
    logic [4:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic [5:0] in_tag = '0;
    logic       wb_valid;
    logic [5:0] wb_tag;
    logic [4:0] wb_dst;

    int    cyc = 0;
    int    n_checks = 0;
    int    n_fails = 0;
    bit    finished = 1'b0;
    int    q_tag[$];
    int    q_dst[$];
    int    q_cyc[$];
    string q_req[$];

    always #4 clk = ~clk;

    ooo_issue_window u_ooo_issue_window (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_is_div(in_is_div),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_tag(in_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_dst(wb_dst)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_wb(input int tg, input int d, input int c, input string req);
        q_tag.push_back(tg); q_dst.push_back(d);
        q_cyc.push_back(c);  q_req.push_back(req);
    endtask

    // Called at a falling edge; returns the edge on which the operation was taken.
    task automatic send(input bit dv, input int d, input int a, input int b,
                        input int tg, output int acc);
        in_is_div = dv;
        in_dst = 5'(d); in_src_a = 5'(a); in_src_b = 5'(b);
        in_tag = 6'(tg);
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        acc = cyc + 1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (q_tag.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: every writeback must match the head of the expectation queue.
    always @(negedge clk) begin : monitor
        int t, d, c;
        string r;
        if (rst_n && !finished && wb_valid) begin
            n_checks++;
            if (q_tag.size() == 0) begin
                n_fails++;
                $display("FAIL unexpected writeback: actual tag %0d cycle %0d expected none",
                         wb_tag, cyc);
            end else begin
                t = q_tag.pop_front(); d = q_dst.pop_front();
                c = q_cyc.pop_front(); r = q_req.pop_front();
                if (int'(wb_tag) != t || int'(wb_dst) != d || cyc != c) begin
                    n_fails++;
                    $display("FAIL %s: actual tag %0d dst %0d cycle %0d expected tag %0d dst %0d cycle %0d",
                             r, wb_tag, wb_dst, cyc, t, d, c);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        int e0, e1, e2, e3, e4, e5, e6;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(in_ready == 1'b1, "R10 ready in reset", int'(in_ready), 1);
        check(wb_valid == 1'b0, "R10 no writeback in reset", int'(wb_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R10 ready after reset", int'(in_ready), 1);
        check(wb_valid == 1'b0, "R10 idle after reset", int'(wb_valid), 0);

        // R3 R4 R11: div f0; add f10<-f0,f8 (RAW); sub f12<-f8,f14 starts early
        send(1'b1, 0, 2, 4, 1, e0);
        send(1'b0, 10, 0, 8, 2, e1);
        send(1'b0, 12, 8, 14, 3, e2);
        expect_wb(3, 12, e2 + 4, "R3 R11 independent add passes");
        expect_wb(1, 0, e0 + 7, "R2 divide latency");
        expect_wb(2, 10, e0 + 7 + 1 + 4, "R4 RAW waits for writeback");
        drain();

        // R5: second writer of f10 waits for the first to write back
        send(1'b1, 0, 2, 4, 4, e0);
        send(1'b0, 10, 0, 8, 5, e1);
        send(1'b0, 10, 8, 14, 6, e2);
        expect_wb(4, 0, e0 + 7, "R2 divide latency");
        expect_wb(5, 10, e0 + 12, "R4 RAW consumer");
        expect_wb(6, 10, e0 + 17, "R5 WAW waits");
        drain();

        // R6: writer of f5 waits while an older reader of f5 is in the window
        send(1'b1, 1, 2, 3, 7, e0);
        send(1'b0, 4, 1, 5, 8, e1);
        send(1'b0, 5, 6, 7, 9, e2);
        expect_wb(7, 1, e0 + 7, "R2 divide latency");
        expect_wb(8, 4, e0 + 12, "R4 RAW consumer");
        expect_wb(9, 5, e0 + 13, "R6 WAR waits for reader to leave");
        drain();

        // R8: two adds released together start oldest first
        send(1'b0, 1, 2, 3, 10, e0);
        send(1'b0, 5, 1, 1, 11, e1);
        send(1'b0, 6, 1, 1, 12, e2);
        expect_wb(10, 1, e0 + 4, "R2 add latency");
        expect_wb(11, 5, e0 + 9, "R8 oldest eligible first");
        expect_wb(12, 6, e0 + 10, "R8 younger eligible next");
        drain();

        // R9 R7: divide older than colliding add; add pipe frozen one cycle
        send(1'b1, 9, 10, 11, 13, e0);
        repeat (2) @(negedge clk);
        send(1'b0, 12, 13, 14, 14, e1);
        send(1'b0, 15, 16, 17, 15, e2);
        check(e1 == e0 + 3, "R9 setup spacing", e1 - e0, 3);
        expect_wb(13, 9, e0 + 7, "R9 older divide wins port");
        expect_wb(14, 12, e0 + 8, "R9 add held one cycle");
        expect_wb(15, 15, e0 + 9, "R7 R9 back-to-back add frozen behind");
        drain();

        // R9: add older than colliding divide; divide held
        send(1'b0, 1, 2, 3, 16, e0);
        send(1'b0, 4, 1, 5, 17, e1);
        send(1'b1, 6, 7, 8, 18, e2);
        expect_wb(16, 1, e0 + 4, "R2 add latency");
        expect_wb(17, 4, e0 + 9, "R9 older add wins port");
        expect_wb(18, 6, e0 + 10, "R9 divide held one cycle");
        drain();

        // R1 R7: window fills behind a busy divider
        send(1'b1, 20, 1, 2, 19, e0);
        send(1'b1, 21, 1, 2, 20, e1);
        send(1'b1, 22, 1, 2, 21, e2);
        send(1'b1, 23, 1, 2, 22, e3);
        send(1'b1, 24, 1, 2, 23, e4);
        expect_wb(19, 20, e0 + 7, "R2 divide latency");
        expect_wb(20, 21, e0 + 15, "R7 divider unpipelined");
        expect_wb(21, 22, e0 + 23, "R7 R8 divider order");
        expect_wb(22, 23, e0 + 31, "R7 R8 divider order");
        expect_wb(23, 24, e0 + 39, "R7 R8 divider order");
        expect_wb(24, 25, e0 + 47, "R1 R7 late entry");
        check(in_ready == 1'b0, "R1 ready low when full", int'(in_ready), 0);
        send(1'b1, 25, 1, 2, 24, e5);
        check(e5 == e0 + 10, "R1 accept after a slot frees", e5 - e0, 10);
        drain();

        e6 = q_tag.size();
        check(e6 == 0, "R2 all expected writebacks seen", e6, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule